// File: doc/BRIEF.md
# Ring-Addressed FIFO Queue

This block is a single-clock first-in first-out queue. Words are kept in a small addressed memory that is used as a ring. Data is never shifted between slots. A write address register picks the slot for each incoming word. A read address register picks the slot of the oldest word. Each register moves forward by one on an accepted operation and wraps through the unsigned overflow of its width.

Full and empty come from comparing the two address registers only. The queue is empty when the two registers are equal. It is full when the write register, plus one, would land on the read register. One slot is therefore always left unused, so a queue of depth `DEPTH` holds at most `DEPTH-1` words.

A producer drives `pushValid` with `pushData`. A consumer drives `popReq` and receives the word on `popData` one cycle later. An occupancy count is also provided. A request that cannot be served has no effect on the stored contents and raises a one-cycle error pulse.

Top module: `ringQueue`

## Requirements
- R1: With `rst` high at a clock edge, both address registers clear: the next cycle shows `isEmpty`=1, `isFull`=0, `fillCount`=0, `popData`=0, and both error pulses low.
- R2: Words leave the queue in the order in which they were accepted.
- R3: The queue holds at most `DEPTH-1` words. `isFull` is 1 exactly when `fillCount` equals `DEPTH-1`. `isFull` and `isEmpty` are never both 1.
- R4: A push while full without a pop is ignored: no stored word and no count changes, and `overflowErr` is 1 for the cycle that follows. When the request is not repeated, the pulse lasts one cycle only.
- R5: A pop while empty is ignored: `popData` and `fillCount` keep their values, and `underflowErr` is 1 for the cycle that follows.
- R6: After an accepted pop, `popData` shows the oldest word from the next cycle on. When no pop is accepted, `popData` holds its last value.
- R7: `fillCount` equals the write address minus the read address, modulo `DEPTH`. It rises by one after an accepted push alone and falls by one after an accepted pop alone.
- R8: A push and a pop in the same cycle while full are both accepted. The queue stays full and no overflow is flagged.
- R9: A push and a pop in the same cycle while empty store the pushed word only. The count becomes 1 and `underflowErr` pulses.
- R10: Operation stays correct after the address registers wrap past `DEPTH-1` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pushValid | input | 1 | Write strobe |
| pushData | input | DATA_W | Word to store |
| popReq | input | 1 | Read strobe |
| popData | output | DATA_W | Registered oldest word, updated after an accepted pop |
| isFull | output | 1 | Queue holds DEPTH-1 words |
| isEmpty | output | 1 | Queue holds no word |
| fillCount | output | log2(DEPTH) | Words currently held |
| overflowErr | output | 1 | One-cycle pulse after a rejected push |
| underflowErr | output | 1 | One-cycle pulse after a rejected pop |

## Verification
The properties assume that `pushValid` and `popReq` are clean, known levels sampled at each rising edge, and that `rst` is high from time zero until at least one edge has passed. The rules for hold and stability also assume that `DEPTH` is at least 2, so a full queue is never also empty. The bench holds reset high from the start. It changes every input only on the falling edge, never near a sampling edge, and it drives no unknown values. The longer hold and wrap checks use the default depth of 8.

// File: rtl/ringq_pkg.sv
package ringq_pkg;

  // Strobes from the control to the datapath, one per accepted operation
  typedef struct packed {
    logic doWrite;   // store pushData at the write address
    logic doRead;    // load the word at the read address into popData
  } ringStrobe_t;

endpackage

// File: rtl/ringq_ctrl.sv
module ringq_ctrl
  import ringq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushValid,
  input  logic             popReq,
  output ringStrobe_t      strobes,
  output logic [PTR_W-1:0] wrAddr,
  output logic [PTR_W-1:0] rdAddr,
  output logic             isFull,
  output logic             isEmpty,
  output logic [PTR_W-1:0] fillCount,
  output logic             overflowErr,
  output logic             underflowErr
);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtrNext;
  logic             acceptPush;
  logic             acceptPop;

  assign wrPtrNext = wrPtr + PTR_W'(1);
  assign isEmpty   = (wrPtr == rdPtr);
  assign isFull    = (wrPtrNext == rdPtr);
  assign fillCount = wrPtr - rdPtr;

  // A pop in the same cycle frees a slot, so a push while full is accepted
  assign acceptPop  = popReq && !isEmpty;
  assign acceptPush = pushValid && (!isFull || acceptPop);

  always_comb begin
    strobes         = '0;
    strobes.doWrite = acceptPush;
    strobes.doRead  = acceptPop;
  end

  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      if (acceptPush) wrPtr <= wrPtrNext;
      if (acceptPop)  rdPtr <= rdPtr + PTR_W'(1);
      overflowErr  <= pushValid && !acceptPush;
      underflowErr <= popReq && !acceptPop;
    end
  end

endmodule

// File: rtl/ringq_dpath.sv
module ringq_dpath
  import ringq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  ringStrobe_t       strobes,
  input  logic [PTR_W-1:0]  wrAddr,
  input  logic [PTR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);

  logic [DATA_W-1:0] ringMem [DEPTH];

  // Storage is not reset: only slots between the two addresses are meaningful
  always_ff @(posedge clk) begin
    if (strobes.doWrite) ringMem[wrAddr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst)                 popData <= '0;
    else if (strobes.doRead) popData <= ringMem[rdAddr];
  end

endmodule

// File: rtl/ringQueue.sv
module ringQueue
  import ringq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              isFull,
  output logic              isEmpty,
  output logic [PTR_W-1:0]  fillCount,
  output logic              overflowErr,
  output logic              underflowErr
);

  ringStrobe_t      strobes;
  logic [PTR_W-1:0] wrAddr;
  logic [PTR_W-1:0] rdAddr;

  ringq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .pushValid    (pushValid),
    .popReq       (popReq),
    .strobes      (strobes),
    .wrAddr       (wrAddr),
    .rdAddr       (rdAddr),
    .isFull       (isFull),
    .isEmpty      (isEmpty),
    .fillCount    (fillCount),
    .overflowErr  (overflowErr),
    .underflowErr (underflowErr)
  );

  ringq_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .pushData (pushData),
    .popData  (popData)
  );

endmodule

// File: rtl/ringq_chk.sv
module ringq_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              pushValid,
  input logic              popReq,
  input logic [DATA_W-1:0] popData,
  input logic              isFull,
  input logic              isEmpty,
  input logic [PTR_W-1:0]  fillCount,
  input logic              overflowErr,
  input logic              underflowErr
);

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(isFull && isEmpty));

  p_full_count_r3: assert property (@(posedge clk) disable iff (rst)
    isFull == (fillCount == PTR_W'(DEPTH - 1)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (pushValid && isFull && !popReq) |=> ($stable(fillCount) && overflowErr && isFull));

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (popReq && isEmpty && !pushValid) |=> ($stable(popData) && underflowErr && isEmpty));

  p_hold_data_r6: assert property (@(posedge clk) disable iff (rst)
    !(popReq && !isEmpty) |=> $stable(popData));

  p_count_up_r7: assert property (@(posedge clk) disable iff (rst)
    (pushValid && !popReq && !isFull) |=> (fillCount == PTR_W'($past(fillCount) + 1'b1)));

  p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
    (popReq && !pushValid && !isEmpty) |=> (fillCount == PTR_W'($past(fillCount) - 1'b1)));

  p_both_full_r8: assert property (@(posedge clk) disable iff (rst)
    (pushValid && popReq && isFull) |=> (isFull && !overflowErr));

  p_both_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (pushValid && popReq && isEmpty) |=> (fillCount == PTR_W'(1) && underflowErr));

endmodule

bind ringQueue ringq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .pushValid    (pushValid),
  .popReq       (popReq),
  .popData      (popData),
  .isFull       (isFull),
  .isEmpty      (isEmpty),
  .fillCount    (fillCount),
  .overflowErr  (overflowErr),
  .underflowErr (underflowErr)
);

// File: tb/ringQueue_tb_top.sv
`timescale 1ns/1ps
module ringQueue_tb_top;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int NVEC   = 24;

  // {push, pop, data[7:0], expCount[2:0], expFull, expEmpty, expOvf, expUdf, expData[7:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0,1'b1,8'h00, 3'd0,1'b0,1'b1,1'b0,1'b1, 8'h00}, // R5 pop while empty
    {1'b1,1'b0,8'h11, 3'd1,1'b0,1'b0,1'b0,1'b0, 8'h00}, // R7
    {1'b1,1'b0,8'h22, 3'd2,1'b0,1'b0,1'b0,1'b0, 8'h00},
    {1'b0,1'b1,8'h00, 3'd1,1'b0,1'b0,1'b0,1'b0, 8'h11}, // R2 R6
    {1'b1,1'b1,8'h33, 3'd1,1'b0,1'b0,1'b0,1'b0, 8'h22},
    {1'b1,1'b0,8'h44, 3'd2,1'b0,1'b0,1'b0,1'b0, 8'h22}, // R6 hold
    {1'b1,1'b0,8'h55, 3'd3,1'b0,1'b0,1'b0,1'b0, 8'h22},
    {1'b1,1'b0,8'h66, 3'd4,1'b0,1'b0,1'b0,1'b0, 8'h22},
    {1'b1,1'b0,8'h77, 3'd5,1'b0,1'b0,1'b0,1'b0, 8'h22},
    {1'b1,1'b0,8'h88, 3'd6,1'b0,1'b0,1'b0,1'b0, 8'h22},
    {1'b1,1'b0,8'h99, 3'd7,1'b1,1'b0,1'b0,1'b0, 8'h22}, // R3 full at DEPTH-1
    {1'b1,1'b0,8'hAA, 3'd7,1'b1,1'b0,1'b1,1'b0, 8'h22}, // R4 overflow
    {1'b1,1'b1,8'hBB, 3'd7,1'b1,1'b0,1'b0,1'b0, 8'h33}, // R8 push+pop while full
    {1'b0,1'b0,8'h00, 3'd7,1'b1,1'b0,1'b0,1'b0, 8'h33}, // R4 one-cycle pulse
    {1'b0,1'b1,8'h00, 3'd6,1'b0,1'b0,1'b0,1'b0, 8'h44},
    {1'b0,1'b1,8'h00, 3'd5,1'b0,1'b0,1'b0,1'b0, 8'h55},
    {1'b0,1'b1,8'h00, 3'd4,1'b0,1'b0,1'b0,1'b0, 8'h66},
    {1'b0,1'b1,8'h00, 3'd3,1'b0,1'b0,1'b0,1'b0, 8'h77},
    {1'b0,1'b1,8'h00, 3'd2,1'b0,1'b0,1'b0,1'b0, 8'h88},
    {1'b0,1'b1,8'h00, 3'd1,1'b0,1'b0,1'b0,1'b0, 8'h99},
    {1'b0,1'b1,8'h00, 3'd0,1'b0,1'b1,1'b0,1'b0, 8'hBB}, // R10 after wrap, AA dropped
    {1'b0,1'b1,8'h00, 3'd0,1'b0,1'b1,1'b0,1'b1, 8'hBB}, // R5 hold on underflow
    {1'b1,1'b1,8'hCC, 3'd1,1'b0,1'b0,1'b0,1'b1, 8'hBB}, // R9 push+pop while empty
    {1'b0,1'b1,8'h00, 3'd0,1'b0,1'b1,1'b0,1'b0, 8'hCC}  // R10
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pushValid = 1'b0;
  logic [DATA_W-1:0] pushData = '0;
  logic              popReq = 1'b0;
  logic [DATA_W-1:0] popData;
  logic              isFull;
  logic              isEmpty;
  logic [PTR_W-1:0]  fillCount;
  logic              overflowErr;
  logic              underflowErr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  ringQueue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .pushValid    (pushValid),
    .pushData     (pushData),
    .popReq       (popReq),
    .popData      (popData),
    .isFull       (isFull),
    .isEmpty      (isEmpty),
    .fillCount    (fillCount),
    .overflowErr  (overflowErr),
    .underflowErr (underflowErr)
  );

  task automatic checkState(input string tag, input logic [PTR_W-1:0] eCnt,
                            input logic eFull, input logic eEmpty,
                            input logic eOvf, input logic eUdf,
                            input logic [DATA_W-1:0] eData);
    nChecks++;
    if (fillCount !== eCnt || isFull !== eFull || isEmpty !== eEmpty ||
        overflowErr !== eOvf || underflowErr !== eUdf || popData !== eData) begin
      nFails++;
      $display("FAIL %s: got cnt=%0d full=%b empty=%b ovf=%b udf=%b data=%h, expected cnt=%0d full=%b empty=%b ovf=%b udf=%b data=%h",
               tag, fillCount, isFull, isEmpty, overflowErr, underflowErr, popData,
               eCnt, eFull, eEmpty, eOvf, eUdf, eData);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic p, input logic q, input logic [DATA_W-1:0] d);
    pushValid = p;
    popReq    = q;
    pushData  = d;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    pushValid = 1'b0;
    popReq = 1'b0;
    // R1: state after reset
    checkState("R1 reset state", 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][24], VEC[i][23], VEC[i][22:15]);
      checkState($sformatf("vector %0d (R2-order/R3/R4/R5/R6/R7/R8/R9/R10)", i),
                 VEC[i][14:12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end

    // R1: reset in the middle of operation discards held words
    step(1'b1, 1'b0, 8'h5A);
    step(1'b1, 1'b1, 8'hA5);
    checkState("R6 before reset", 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A);
    rst = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    rst = 1'b0;
    checkState("R1 reset mid-run", 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'h00);
    checkState("R5 empty after reset", 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);

    // R2 R10: several full fill/drain rounds to wrap the addresses repeatedly
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < DEPTH - 1; k++) step(1'b1, 1'b0, DATA_W'(8'h40 + r * 16 + k));
      checkState($sformatf("R3 full in round %0d", r), 3'(DEPTH - 1), 1'b1, 1'b0, 1'b0, 1'b0,
                 (r == 0) ? 8'h00 : DATA_W'(8'h40 + (r - 1) * 16 + DEPTH - 2));
      for (int k = 0; k < DEPTH - 1; k++) begin
        step(1'b0, 1'b1, 8'h00);
        checkState($sformatf("R2 R10 round %0d pop %0d", r, k), 3'(DEPTH - 2 - k),
                   1'b0, (k == DEPTH - 2), 1'b0, 1'b0, DATA_W'(8'h40 + r * 16 + k));
      end
    end

    step(1'b0, 1'b0, 8'h00);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule